// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block governs the way out of a clock-stopped standby state. Software asks for standby with a one-cycle request. The controller then records the current level of every wake input and latches the settling-period select. It drops the oscillator enable and the chip clock gate. While standby holds, it watches one non-maskable interrupt line and eight maskable request lines. Each line has its own choice of rising or falling edge. A maskable line counts only when its priority is above the CPU's current mask level.

When a qualified edge arrives, the controller turns the oscillator enable back on. It keeps the chip clock gated while a settling counter runs for 2^(8+2*sel) cycles. When the counter expires, it opens the chip clock and emits a one-cycle wake pulse with a code naming the source. A synchronous reset cancels standby at once, with no settling, and leaves both clocks running. After reset is released, the controller issues a one-cycle pulse that starts reset exception handling.

Top module: `stby_wake_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after any edge at which it was high, `osc_en`=1, `chip_clk_en`=1 and `wake_vld`=0. This holds in every state, so a reset during standby or settling resumes the clocks on the next edge without waiting for settling.
- R2: `por_exc` is high for exactly one cycle. That cycle is the one after the first clock edge at which `rst` is sampled low following a reset.
- R3: A `sby_req` sampled high in the running state gives `osc_en`=0 and `chip_clk_en`=0 from the next cycle on. It also captures the levels of `nmi` and `irq` at that edge.
- R4: `nmi_rise`=1 selects a rising NMI edge and 0 selects a falling one. An edge counts only if `nmi` moves away from its captured level in the selected direction. A level already present at entry, or a move in the other direction, does not wake the block.
- R5: Each `irq[n]` has its own polarity bit, `irq_rise[n]` (1 rising, 0 falling). It is qualified against its captured level in the same way as the NMI.
- R6: A request on `irq[n]` wakes the block only if its priority, `irq_pri[4n+3:4n]`, is strictly greater than `cpu_mask`. A refused request leaves standby in place, with both enables low.
- R7: After a qualified edge, `osc_en`=1 and `chip_clk_en`=0 for exactly 2^(8+2*sel) cycles. Here sel is the select value latched at entry. The wake cycle follows.
- R8: `clk_sel` is latched on standby entry. Changing it during standby or settling does not change the current settling period.
- R9: The wake cycle raises `wake_vld` for one cycle, with `chip_clk_en`=1 from then on. `wake_src` is 4'b1000 for the NMI and {1'b0, n} for `irq[n]`.
- R10: When several sources qualify in the same cycle, the NMI wins. Otherwise the lowest-numbered qualified IRQ line wins.
- R11: Input edges during settling or while running change neither the settling length nor the reported source, and they start no extra wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock (oscillator model) |
| rst | input | 1 | Synchronous active-high power-on reset |
| sby_req | input | 1 | One-cycle request to enter standby |
| clk_sel | input | 3 | Settling-period select |
| nmi | input | 1 | Non-maskable wake line |
| nmi_rise | input | 1 | NMI polarity: 1 rising, 0 falling |
| irq | input | 8 | Maskable wake lines |
| irq_rise | input | 8 | Per-line polarity: 1 rising, 0 falling |
| irq_pri | input | 32 | Four-bit priority per line, line n at bits 4n+3:4n |
| cpu_mask | input | 4 | Current CPU interrupt mask level |
| osc_en | output | 1 | Oscillator enable |
| chip_clk_en | output | 1 | Clock gate enable for the whole chip |
| wake_vld | output | 1 | One-cycle wake pulse to the CPU interface |
| wake_src | output | 4 | Wake source code, valid with wake_vld |
| por_exc | output | 1 | One-cycle reset exception start after reset release |

## Verification
The wake path is exercised in several ways:
- Rising and falling NMI edges, and each polarity on single IRQ lines and on a mixed-polarity word. These separate a correct edge check from a plain level check.
- Levels already present at entry, and moves in the wrong direction. These must not wake the block, which shows that the captured snapshot is actually used.
- Priorities below, equal to and above the mask. These pin down the strict comparison.
- Simultaneous requests, which fix the arbitration order.
- Settling lengths measured for three select values, plus a select changed mid-standby. These show that the period is taken from the value latched at entry.
- Reset applied during standby and during settling, which separates immediate cancellation from a wake that waits for the counter.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SBY    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_WAKE   = 2'd3
  } sbw_state_e;
endpackage

// File: rtl/sbw_edge_qual.sv
module sbw_edge_qual #(
  parameter int N  = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snap,
  input  logic [N-1:0]  sig,
  input  logic [N-1:0]  rise,
  input  logic [N*PW-1:0] pri,
  input  logic [PW-1:0] mask,
  output logic [N-1:0]  hit
);
  logic [N-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst) ref_q <= '0;
    else if (snap) ref_q <= sig;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic moved;
    logic pri_ok;
    assign moved  = rise[i] ? (~ref_q[i] & sig[i]) : (ref_q[i] & ~sig[i]);
    assign pri_ok = pri[i*PW +: PW] > mask;
    assign hit[i] = moved & pri_ok;
  end
endmodule

// File: rtl/sbw_src_pick.sv
module sbw_src_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N),
  localparam int SW = IW + 1
) (
  input  logic          nmi_hit,
  input  logic [N-1:0]  irq_hit,
  output logic          vld,
  output logic [SW-1:0] src
);
  always_comb begin
    vld = nmi_hit | (|irq_hit);
    src = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (irq_hit[i]) src = {1'b0, IW'(i)};
    end
    if (nmi_hit) src = {1'b1, {IW{1'b0}}};
  end
endmodule

// File: rtl/sbw_settle_cnt.sv
module sbw_settle_cnt #(
  parameter int BASE_LOG = 8,
  parameter int STEP_LOG = 2,
  parameter int SEL_W    = 3,
  localparam int MAX_SH  = BASE_LOG + STEP_LOG * ((1 << SEL_W) - 1),
  localparam int CW      = MAX_SH + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  output logic             done
);
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) sel_q <= sel;
      if (!run) cnt_q <= '0;
      else      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_comb lim = (CW'(1) << (BASE_LOG + STEP_LOG * int'(sel_q))) - CW'(1);

  assign done = run && (cnt_q == lim);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= lim));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(sel_q));
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import sbw_pkg::*;
#(
  parameter int NIRQ     = 8,
  parameter int PW       = 4,
  parameter int SEL_W    = 3,
  parameter int BASE_LOG = 8,
  parameter int STEP_LOG = 2,
  localparam int SW      = $clog2(NIRQ) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sby_req,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic              nmi,
  input  logic              nmi_rise,
  input  logic [NIRQ-1:0]   irq,
  input  logic [NIRQ-1:0]   irq_rise,
  input  logic [NIRQ*PW-1:0] irq_pri,
  input  logic [PW-1:0]     cpu_mask,
  output logic              osc_en,
  output logic              chip_clk_en,
  output logic              wake_vld,
  output logic [SW-1:0]     wake_src,
  output logic              por_exc
);
  sbw_state_e state_q, state_d;
  logic       enter;
  logic       nmi_hit;
  logic [NIRQ-1:0] irq_hit;
  logic       pick_vld;
  logic [SW-1:0] pick_src;
  logic       settle_done;
  logic       rst_seen_q;

  assign enter = (state_q == ST_RUN) && sby_req;

  // NMI: priority forced above any mask so it always passes the gate
  sbw_edge_qual #(.N(1), .PW(PW)) u_nmi_qual (
    .clk(clk), .rst(rst), .snap(enter),
    .sig(nmi), .rise(nmi_rise),
    .pri({PW{1'b1}}), .mask({PW{1'b0}}),
    .hit(nmi_hit)
  );

  sbw_edge_qual #(.N(NIRQ), .PW(PW)) u_irq_qual (
    .clk(clk), .rst(rst), .snap(enter),
    .sig(irq), .rise(irq_rise),
    .pri(irq_pri), .mask(cpu_mask),
    .hit(irq_hit)
  );

  sbw_src_pick #(.N(NIRQ)) u_pick (
    .nmi_hit(nmi_hit), .irq_hit(irq_hit),
    .vld(pick_vld), .src(pick_src)
  );

  sbw_settle_cnt #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .load(enter), .sel(clk_sel),
    .run(state_q == ST_SETTLE), .done(settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (sby_req)     state_d = ST_SBY;
      ST_SBY:    if (pick_vld)    state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_WAKE;
      ST_WAKE:                    state_d = ST_RUN;
      default:                    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      osc_en      <= 1'b1;
      chip_clk_en <= 1'b1;
      wake_vld    <= 1'b0;
      wake_src    <= '0;
      por_exc     <= 1'b0;
      rst_seen_q  <= 1'b1;
    end else begin
      state_q     <= state_d;
      osc_en      <= (state_d != ST_SBY);
      chip_clk_en <= (state_d == ST_RUN) || (state_d == ST_WAKE);
      wake_vld    <= (state_d == ST_WAKE);
      if (state_q == ST_SBY && pick_vld) wake_src <= pick_src;
      por_exc     <= rst_seen_q;
      rst_seen_q  <= 1'b0;
    end
  end

  // R1
  rst_cancel_chk: assert property (@(posedge clk)
    rst |=> (osc_en && chip_clk_en && !wake_vld));

  // R3
  entry_chk: assert property (@(posedge clk) disable iff (rst)
    enter |=> (!osc_en && !chip_clk_en));

  // R7
  gate_order_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !chip_clk_en);

  // R9
  wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake_vld |=> !wake_vld);

  // R9
  wake_clk_chk: assert property (@(posedge clk) disable iff (rst)
    wake_vld |-> chip_clk_en);

  // R2
  por_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    por_exc |=> !por_exc);
endmodule

// File: tb/stby_wake_ctrl_tb_top.sv
module stby_wake_ctrl_tb_top;
  typedef struct packed {
    logic [2:0]  cks;
    logic        nmi_r;
    logic [7:0]  irq_r;
    logic        nmi_e;
    logic [7:0]  irq_e;
    logic        nmi_w;
    logic [7:0]  irq_w;
    logic [3:0]  mask;
    logic [31:0] pri;
    logic        exp_wake;
    logic [3:0]  exp_src;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 4'd4, 32'h8888_8888, 1'b1, 4'h8}, // R4 nmi rise
    '{3'd0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 8'h00, 4'd4, 32'h8888_8888, 1'b1, 4'h8}, // R4 nmi fall
    '{3'd0, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1, 8'h00, 4'd4, 32'h8888_8888, 1'b0, 4'h0}, // R4 level at entry
    '{3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 4'd4, 32'h8888_8888, 1'b0, 4'h0}, // R4 wrong direction
    '{3'd1, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h08, 4'd4, 32'h8888_8888, 1'b1, 4'h3}, // R5 rise line3
    '{3'd2, 1'b1, 8'h00, 1'b0, 8'hFF, 1'b0, 8'hDF, 4'd4, 32'h8888_8888, 1'b1, 4'h5}, // R5 fall line5
    '{3'd0, 1'b1, 8'h0F, 1'b0, 8'hF0, 1'b0, 8'hF4, 4'd4, 32'h8888_8888, 1'b1, 4'h2}, // R5 mixed
    '{3'd0, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h02, 4'd4, 32'h8888_8838, 1'b0, 4'h0}, // R6 below
    '{3'd0, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h02, 4'd4, 32'h8888_8848, 1'b0, 4'h0}, // R6 equal
    '{3'd0, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h42, 4'd4, 32'h8888_8828, 1'b1, 4'h6}, // R6 R10
    '{3'd0, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h24, 4'd4, 32'h8888_8888, 1'b1, 4'h2}, // R10 lowest
    '{3'd0, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b1, 8'h01, 4'd4, 32'h8888_8888, 1'b1, 4'h8}  // R10 nmi first
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sby_req = 1'b0;
  logic [2:0]  clk_sel = '0;
  logic        nmi = 1'b0;
  logic        nmi_rise = 1'b1;
  logic [7:0]  irq = '0;
  logic [7:0]  irq_rise = '0;
  logic [31:0] irq_pri = '0;
  logic [3:0]  cpu_mask = '0;
  logic        osc_en, chip_clk_en, wake_vld, por_exc;
  logic [3:0]  wake_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stby_wake_ctrl dut_i (
    .clk(clk), .rst(rst), .sby_req(sby_req), .clk_sel(clk_sel),
    .nmi(nmi), .nmi_rise(nmi_rise), .irq(irq), .irq_rise(irq_rise),
    .irq_pri(irq_pri), .cpu_mask(cpu_mask),
    .osc_en(osc_en), .chip_clk_en(chip_clk_en), .wake_vld(wake_vld),
    .wake_src(wake_src), .por_exc(por_exc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enter_sby(input logic [2:0] cks);
    @(negedge clk);
    clk_sel = cks;
    sby_req = 1'b1;
    @(negedge clk);
    sby_req = 1'b0;
    chk(!osc_en && !chip_clk_en, "R3 enables off after entry", {osc_en, chip_clk_en}, 0);
  endtask

  task automatic measure(output int n, output bit woke);
    n = 0;
    woke = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (wake_vld) begin
        woke = 1'b1;
        break;
      end
      if (osc_en && !chip_clk_en) n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(osc_en && chip_clk_en && !wake_vld, "R1 reset cancels standby", {osc_en, chip_clk_en, wake_vld}, 6);
    rst = 1'b0;
    @(negedge clk);
    chk(por_exc == 1'b1, "R2 reset exception pulse", por_exc, 1);
    @(negedge clk);
    chk(por_exc == 1'b0, "R2 pulse one cycle", por_exc, 0);
  endtask

  task automatic run_case(input vec_t v);
    int n;
    bit woke;
    @(negedge clk);
    nmi_rise = v.nmi_r; irq_rise = v.irq_r;
    nmi = v.nmi_e; irq = v.irq_e;
    cpu_mask = v.mask; irq_pri = v.pri;
    enter_sby(v.cks);
    repeat (3) @(negedge clk);
    nmi = v.nmi_w; irq = v.irq_w;
    if (v.exp_wake) begin
      measure(n, woke);
      chk(woke, "R4 R5 R6 R10 wake occurs", woke, 1);
      chk(n == (1 << (8 + 2 * v.cks)), "R7 settling length", n, 1 << (8 + 2 * v.cks));
      chk(wake_src == v.exp_src, "R9 R10 wake source", wake_src, v.exp_src);
      chk(chip_clk_en, "R9 clock on at wake", chip_clk_en, 1);
      @(negedge clk);
      chk(!wake_vld && chip_clk_en, "R9 single pulse", {wake_vld, chip_clk_en}, 1);
    end else begin
      woke = 1'b0;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        if (wake_vld || osc_en) woke = 1'b1;
      end
      chk(!woke && !chip_clk_en, "R4 R6 no wake, standby holds", woke, 0);
      do_reset();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    bit woke;
    repeat (2) @(negedge clk);
    chk(osc_en && chip_clk_en && !wake_vld, "R1 reset state", {osc_en, chip_clk_en, wake_vld}, 6);
    rst = 1'b0;
    @(negedge clk);
    chk(por_exc, "R2 pulse after release", por_exc, 1);
    @(negedge clk);
    chk(!por_exc, "R2 pulse ends", por_exc, 0);

    // R11: edges while running do nothing
    nmi_rise = 1'b1; irq_rise = 8'hFF; irq_pri = 32'h8888_8888; cpu_mask = 4'd4;
    nmi = 1'b1; irq = 8'hFF;
    repeat (3) @(negedge clk);
    chk(osc_en && chip_clk_en && !wake_vld, "R11 run ignores edges", {osc_en, chip_clk_en, wake_vld}, 6);
    nmi = 1'b0; irq = 8'h00;

    for (int k = 0; k < NV; k++) run_case(TBL[k]);

    // R8 and R11: select changed mid-standby, extra edges during settling
    @(negedge clk);
    nmi_rise = 1'b1; nmi = 1'b0; irq = 8'h00; irq_rise = 8'hFF;
    enter_sby(3'd1);
    clk_sel = 3'd0;
    @(negedge clk);
    nmi = 1'b1;
    repeat (10) @(negedge clk);
    irq = 8'h01;
    clk_sel = 3'd2;
    measure(n, woke);
    n = n + 10;
    chk(woke && n == 1024, "R8 latched select period", n, 1024);
    chk(wake_src == 4'h8, "R11 source unchanged by later edge", wake_src, 8);
    @(negedge clk);
    irq = 8'h00; nmi = 1'b0;

    // R1: reset during settling cancels at once
    enter_sby(3'd2);
    nmi = 1'b1;
    repeat (50) @(negedge clk);
    chk(osc_en && !chip_clk_en, "R7 settling in progress", {osc_en, chip_clk_en}, 2);
    do_reset();
    repeat (5000) @(negedge clk);
    woke = 1'b0;
    chk(chip_clk_en && !wake_vld, "R1 no late wake after reset", wake_vld, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule